// File: doc/BRIEF.md
# Double-precision to signed 32-bit integer converter

This block turns one IEEE-754 binary64 operand into a two's-complement 32-bit integer. The rounding applied to a value with a fractional part comes from a 2-bit mode input. Beside the integer, the block raises two flags. The first, invalid, marks a result that cannot be given. The second, inexact, marks a result that lost a fraction. Values that are out of range, and all NaN and infinity inputs, do not saturate. They return the sentinel 0x80000000 with invalid set. A finite value that rounds to exactly -2^31 is an ordinary valid result, and it carries the same bit pattern.

The datapath runs in three stages: field decode and classification, alignment of the significand against the integer point, then rounding with a range check. A generate switch either places one output register after the datapath, or passes the result straight through. In the registered form, a clock enable loads the register. With the enable low, the last result and its flags hold.

Top module: `f64_i32_conv`

## Requirements
- R1: A finite normal operand whose rounded value lies in [-2^31, 2^31-1] gives that rounded value on `res_o` in two's complement. A non-negative operand never gives a negative valid result.
- R2: `rmode_i` picks the rounding: 2'b00 rounds to nearest with ties to even, 2'b01 rounds toward minus infinity, 2'b10 rounds toward plus infinity, and 2'b11 truncates toward zero.
- R3: `inexact_o` is 1 exactly when a valid result differs from the operand, meaning the discarded fraction was nonzero. An exact integer operand gives `inexact_o` = 0.
- R4: A finite operand whose rounded value falls outside [-2^31, 2^31-1] gives `res_o` = 32'h8000_0000, `invalid_o` = 1 and `inexact_o` = 0.
- R5: An operand with every exponent bit (62:52) set gives 32'h8000_0000 with `invalid_o` = 1 and `inexact_o` = 0. This covers both infinities and every NaN.
- R6: An operand that rounds to exactly -2^31 gives 32'h8000_0000 with `invalid_o` = 0. `inexact_o` follows R3.
- R7: An operand whose exponent bits are all zero gives 0 in every rounding mode. `inexact_o` is 1 only if the fraction bits 51:0 are nonzero. `invalid_o` stays 0.
- R8: With the output register built, `res_o` and both flags clear to 0 in reset. They take the result of the operand presented at a rising clock edge where `en_i` = 1. They hold their value across edges where `en_i` = 0.
- R9: `invalid_o` and `inexact_o` are never 1 together, and `invalid_o` = 1 always comes with `res_o` = 32'h8000_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Load enable for the output register |
| op_i | input | 64 | Binary64 operand |
| rmode_i | input | 2 | Rounding mode (00 nearest-even, 01 down, 10 up, 11 to zero) |
| res_o | output | 32 | Signed integer result or sentinel |
| invalid_o | output | 1 | Result unrepresentable, or operand was NaN or infinity |
| inexact_o | output | 1 | A valid result was rounded |

## Verification
Rounding and the range check can act on the same operand in the same cycle. An operand just below 2^31 or just beyond -2^31 can be pushed across the limit by the rounding increment alone. So the same operand must give invalid under one mode and a valid, inexact result under another. The bench applies values such as 2147483647.5 and -2147483648.5 under several modes. It judges each one on all three outputs: the overflow case must drop inexact, and the -2^31 case must keep the sentinel pattern without invalid.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  localparam int FP_W  = 64;
  localparam int EXP_W = 11;
  localparam int MAN_W = 52;
  localparam int BIAS  = 1023;
  localparam int UEXP_W = EXP_W + 2;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  typedef struct packed {
    logic              sign;
    logic              is_nan;
    logic              is_inf;
    logic              is_zero;
    logic              is_sub;
    logic [UEXP_W-1:0] uexp;
    logic [MAN_W:0]    sig;
  } fp_unpk_t;
endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack
  import f2i_pkg::*;
(
  input  logic [FP_W-1:0] op_i,
  output fp_unpk_t        unpk_o
);
  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             exp_max, exp_min, man_nz;

  always_comb begin
    exp_f   = op_i[FP_W-2 -: EXP_W];
    man_f   = op_i[MAN_W-1:0];
    exp_max = &exp_f;
    exp_min = ~|exp_f;
    man_nz  = |man_f;
    unpk_o.sign    = op_i[FP_W-1];
    unpk_o.is_nan  = exp_max & man_nz;
    unpk_o.is_inf  = exp_max & ~man_nz;
    unpk_o.is_zero = exp_min & ~man_nz;
    unpk_o.is_sub  = exp_min & man_nz;
    unpk_o.uexp    = {2'b00, exp_f} - UEXP_W'(BIAS);
    unpk_o.sig     = {~exp_min, man_f};
  end
endmodule

// File: rtl/f2i_align.sv
module f2i_align
  import f2i_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  logic [UEXP_W-1:0] uexp_i,
  input  logic [MAN_W:0]    sig_i,
  output logic [INT_W:0]    int_mag_o,
  output logic              rnd_o,
  output logic              sticky_o,
  output logic              too_big_o
);
  localparam int SH_W  = MAN_W + 1 + INT_W;
  localparam int SHA_W = $clog2(INT_W);

  logic signed [UEXP_W-1:0] e;
  logic        [SH_W-1:0]   vec;
  logic        [SH_W-1:0]   shifted;

  always_comb begin
    e         = $signed(uexp_i);
    vec       = {{INT_W{1'b0}}, sig_i};
    shifted   = '0;
    int_mag_o = '0;
    rnd_o     = 1'b0;
    sticky_o  = 1'b0;
    too_big_o = (e >= $signed(UEXP_W'(INT_W)));
    if (!too_big_o && (e >= 0)) begin
      shifted   = vec << e[SHA_W-1:0];
      int_mag_o = shifted[SH_W-1:MAN_W];
      rnd_o     = shifted[MAN_W-1];
      sticky_o  = |shifted[MAN_W-2:0];
    end else if (e == -1) begin
      rnd_o    = 1'b1;
      sticky_o = |sig_i[MAN_W-1:0];
    end else if (!too_big_o) begin
      sticky_o = 1'b1;
    end
  end
endmodule

// File: rtl/f2i_round.sv
module f2i_round
  import f2i_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  logic             sign_i,
  input  logic             is_nan_i,
  input  logic             is_inf_i,
  input  logic             is_zero_i,
  input  logic             is_sub_i,
  input  logic [INT_W:0]   int_mag_i,
  input  logic             rnd_i,
  input  logic             sticky_i,
  input  logic             too_big_i,
  input  rmode_e           rmode_i,
  output logic [INT_W-1:0] res_o,
  output logic             invalid_o,
  output logic             inexact_o
);
  localparam int MW = INT_W + 2;
  localparam logic [MW-1:0] LIM_NEG = MW'(64'd1 << (INT_W-1));
  localparam logic [MW-1:0] LIM_POS = LIM_NEG - MW'(1);
  localparam logic [INT_W-1:0] SENTINEL = {1'b1, {(INT_W-1){1'b0}}};

  logic          incr, loss, ovf;
  logic [MW-1:0] mag_r;
  logic [INT_W-1:0] low;

  always_comb begin
    loss = rnd_i | sticky_i;
    unique case (rmode_i)
      RM_NEAR: incr = rnd_i & (sticky_i | int_mag_i[0]);
      RM_DOWN: incr = sign_i & loss;
      RM_UP:   incr = ~sign_i & loss;
      default: incr = 1'b0;
    endcase
    mag_r = {1'b0, int_mag_i} + MW'(incr);
    ovf   = sign_i ? (mag_r > LIM_NEG) : (mag_r > LIM_POS);
    low   = mag_r[INT_W-1:0];

    res_o     = '0;
    invalid_o = 1'b0;
    inexact_o = 1'b0;
    if (is_nan_i || is_inf_i || too_big_i || (!is_zero_i && !is_sub_i && ovf)) begin
      res_o     = SENTINEL;
      invalid_o = 1'b1;
    end else if (is_sub_i) begin
      inexact_o = 1'b1;
    end else if (!is_zero_i) begin
      res_o     = sign_i ? (~low + 1'b1) : low;
      inexact_o = loss;
    end
  end
endmodule

// File: rtl/f64_i32_conv.sv
module f64_i32_conv
  import f2i_pkg::*;
#(
  parameter int INT_W   = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [FP_W-1:0]  op_i,
  input  logic [1:0]       rmode_i,
  output logic [INT_W-1:0] res_o,
  output logic             invalid_o,
  output logic             inexact_o
);
  fp_unpk_t         unpk;
  logic [INT_W:0]   int_mag;
  logic             rnd, sticky, too_big;
  logic [INT_W-1:0] res_c;
  logic             inv_c, inx_c;

  f2i_unpack u_unpack (.op_i(op_i), .unpk_o(unpk));

  f2i_align #(.INT_W(INT_W)) u_align (
    .uexp_i(unpk.uexp), .sig_i(unpk.sig),
    .int_mag_o(int_mag), .rnd_o(rnd), .sticky_o(sticky), .too_big_o(too_big)
  );

  f2i_round #(.INT_W(INT_W)) u_round (
    .sign_i(unpk.sign), .is_nan_i(unpk.is_nan), .is_inf_i(unpk.is_inf),
    .is_zero_i(unpk.is_zero), .is_sub_i(unpk.is_sub),
    .int_mag_i(int_mag), .rnd_i(rnd), .sticky_i(sticky), .too_big_i(too_big),
    .rmode_i(rmode_e'(rmode_i)),
    .res_o(res_c), .invalid_o(inv_c), .inexact_o(inx_c)
  );

  generate
    if (OUT_REG) begin : g_reg
      logic [INT_W-1:0] res_q, res_d;
      logic             inv_q, inv_d, inx_q, inx_d;

      always_comb begin
        res_d = res_q;
        inv_d = inv_q;
        inx_d = inx_q;
        if (en_i) begin
          res_d = res_c;
          inv_d = inv_c;
          inx_d = inx_c;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          res_q <= '0;
          inv_q <= 1'b0;
          inx_q <= 1'b0;
        end else begin
          res_q <= res_d;
          inv_q <= inv_d;
          inx_q <= inx_d;
        end
      end

      assign res_o     = res_q;
      assign invalid_o = inv_q;
      assign inexact_o = inx_q;
    end else begin : g_comb
      assign res_o     = res_c;
      assign invalid_o = inv_c;
      assign inexact_o = inx_c;
    end
  endgenerate
endmodule

// File: rtl/f64_i32_conv_chk.sv
module f64_i32_conv_chk #(
  parameter int INT_W   = 32,
  parameter bit OUT_REG = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_i,
  input logic [11:0]      op_hi_i,
  input logic [INT_W-1:0] res_o,
  input logic             invalid_o,
  input logic             inexact_o
);
  localparam logic [INT_W-1:0] SENT = {1'b1, {(INT_W-1){1'b0}}};

  generate
    if (OUT_REG) begin : g_chk
      assert_nan_inf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && (&op_hi_i[10:0]) |=> invalid_o && !inexact_o && (res_o == SENT));

      assert_small_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && (op_hi_i[10:0] == 11'd0) |=> (res_o == '0) && !invalid_o);

      assert_pos_nonneg_R1: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && !op_hi_i[11] |=> !res_o[INT_W-1] || invalid_o);

      assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(res_o) && $stable(invalid_o) && $stable(inexact_o));
    end
  endgenerate

  assert_flag_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_o |-> !inexact_o && (res_o == SENT));
endmodule

bind f64_i32_conv f64_i32_conv_chk #(.INT_W(INT_W), .OUT_REG(OUT_REG)) chk_i (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .op_hi_i(op_i[63:52]),
  .res_o(res_o), .invalid_o(invalid_o), .inexact_o(inexact_o)
);

// File: tb/f64_i32_conv_tb_top.sv
module f64_i32_conv_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en_i;
  logic [63:0] op_i;
  logic [1:0]  rmode_i;
  logic [31:0] res_o;
  logic        invalid_o, inexact_o;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [1:0] NE = 2'b00, DN = 2'b01, UP = 2'b10, TZ = 2'b11;
  localparam logic [31:0] SENT = 32'h8000_0000;

  always #5 clk = ~clk;

  f64_i32_conv dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .op_i(op_i), .rmode_i(rmode_i),
    .res_o(res_o), .invalid_o(invalid_o), .inexact_o(inexact_o)
  );

  task automatic check(input string tag, input logic [31:0] er,
                       input logic ei, input logic ex);
    n_chk++;
    if (res_o !== er || invalid_o !== ei || inexact_o !== ex) begin
      n_fail++;
      $display("FAIL %s: got res=%h inv=%b inx=%b, expected res=%h inv=%b inx=%b",
               tag, res_o, invalid_o, inexact_o, er, ei, ex);
    end
  endtask

  // drive at a falling edge, capture at the next rising edge, sample at the following falling edge
  task automatic conv(input string tag, input logic [63:0] op, input logic [1:0] rm,
                      input logic [31:0] er, input logic ei, input logic ex);
    @(negedge clk);
    en_i = 1'b1; op_i = op; rmode_i = rm;
    @(negedge clk);
    check(tag, er, ei, ex);
  endtask

  task automatic t_reset;
    check("R8 reset state", 32'd0, 1'b0, 1'b0);
  endtask

  task automatic t_exact;
    conv("R1 1.0", $realtobits(1.0), NE, 32'd1, 0, 0);
    conv("R1 -7.0", $realtobits(-7.0), TZ, 32'hFFFF_FFF9, 0, 0);
    conv("R1 123456.0", $realtobits(123456.0), UP, 32'd123456, 0, 0);
    conv("R3 max exact", $realtobits(2147483647.0), DN, 32'h7FFF_FFFF, 0, 0);
  endtask

  task automatic t_modes;
    conv("R2 2.5 nearest", $realtobits(2.5), NE, 32'd2, 0, 1);
    conv("R2 3.5 nearest", $realtobits(3.5), NE, 32'd4, 0, 1);
    conv("R2 -2.5 nearest", $realtobits(-2.5), NE, 32'hFFFF_FFFE, 0, 1);
    conv("R2 2.5 down", $realtobits(2.5), DN, 32'd2, 0, 1);
    conv("R2 -2.5 down", $realtobits(-2.5), DN, 32'hFFFF_FFFD, 0, 1);
    conv("R2 2.3 up", $realtobits(2.3), UP, 32'd3, 0, 1);
    conv("R2 -2.7 up", $realtobits(-2.7), UP, 32'hFFFF_FFFE, 0, 1);
    conv("R2 -2.7 zero", $realtobits(-2.7), TZ, 32'hFFFF_FFFE, 0, 1);
    conv("R2 2.7 zero", $realtobits(2.7), TZ, 32'd2, 0, 1);
    conv("R3 0.5 nearest", $realtobits(0.5), NE, 32'd0, 0, 1);
    conv("R3 0.75 nearest", $realtobits(0.75), NE, 32'd1, 0, 1);
    conv("R3 -0.25 down", $realtobits(-0.25), DN, 32'hFFFF_FFFF, 0, 1);
  endtask

  task automatic t_range;
    conv("R4 2^31 zero", $realtobits(2147483648.0), TZ, SENT, 1, 0);
    conv("R4 R9 2^31-0.5 nearest", $realtobits(2147483647.5), NE, SENT, 1, 0);
    conv("R3 2^31-0.5 zero", $realtobits(2147483647.5), TZ, 32'h7FFF_FFFF, 0, 1);
    conv("R4 -2^31-1", $realtobits(-2147483649.0), NE, SENT, 1, 0);
    conv("R4 1e20", $realtobits(1.0e20), UP, SENT, 1, 0);
    conv("R4 -2^31-0.5 down", $realtobits(-2147483648.5), DN, SENT, 1, 0);
  endtask

  task automatic t_min_int;
    conv("R6 -2^31 exact", $realtobits(-2147483648.0), NE, SENT, 0, 0);
    conv("R6 -2^31-0.5 nearest", $realtobits(-2147483648.5), NE, SENT, 0, 1);
    conv("R6 -2^31-0.9 zero", $realtobits(-2147483648.9), TZ, SENT, 0, 1);
  endtask

  task automatic t_special;
    conv("R5 qNaN", 64'h7FF8_0000_0000_0000, NE, SENT, 1, 0);
    conv("R5 sNaN", 64'h7FF0_0000_0000_0001, TZ, SENT, 1, 0);
    conv("R5 +inf", 64'h7FF0_0000_0000_0000, DN, SENT, 1, 0);
    conv("R5 -inf", 64'hFFF0_0000_0000_0000, UP, SENT, 1, 0);
  endtask

  task automatic t_small;
    conv("R7 +0", 64'h0, UP, 32'd0, 0, 0);
    conv("R7 -0", 64'h8000_0000_0000_0000, DN, 32'd0, 0, 0);
    conv("R7 subnormal up", 64'h0000_0000_0000_0001, UP, 32'd0, 0, 1);
    conv("R7 neg subnormal down", 64'h800F_FFFF_FFFF_FFFF, DN, 32'd0, 0, 1);
  endtask

  task automatic t_hold;
    conv("R8 load 9.0", $realtobits(9.0), NE, 32'd9, 0, 0);
    @(negedge clk);
    en_i = 1'b0; op_i = 64'h7FF8_0000_0000_0000; rmode_i = TZ;
    @(negedge clk);
    check("R8 hold 1", 32'd9, 0, 0);
    @(negedge clk);
    check("R8 hold 2", 32'd9, 0, 0);
    en_i = 1'b1;
    @(negedge clk);
    check("R8 reload NaN", SENT, 1, 0);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en_i = 1'b0; op_i = '0; rmode_i = NE;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_exact();
    t_modes();
    t_range();
    t_min_int();
    t_special();
    t_small();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule